// File: doc/BRIEF.md
# Compressed Register-Pair Move Sequencer

This block decodes and carries out two 16-bit compressed instructions. Each one moves a pair of registers as a single indivisible step. The gather form copies two saved registers into the argument registers a0 (x10) and a1 (x11). The scatter form copies a0 and a1 out into two saved registers. Each operand is a 3-bit saved-register index, not a full 5-bit architectural register number, so the block remaps it onto the split saved-register ranges.

The block sits next to the integer register file. It drives two read addresses and takes the read data back in the same cycle. It then issues up to two write requests. Interrupts are held off for as long as any part of a pair is outstanding.

A build parameter selects one of two variants. The first writes both destinations in one cycle through two write ports. The second uses a single write port over two consecutive cycles: it captures both source values at acceptance, raises a busy output, and ignores new instructions until the second write has been issued.

Top module: `pairmv_seq`

## Requirements
- R1: Saved index n (0..7) maps to architectural register 8+n when n<2 and to 16+n otherwise, so the only reachable saved targets are x8, x9 and x18..x23.
- R2: An instruction with bits 15:10 = 101011, bits 1:0 = 10 and bits 6:5 = 11 (gather) writes a0 with the register named by bits 9:7 and a1 with the register named by bits 4:2.
- R3: The same pattern with bits 6:5 = 01 (scatter) writes the register named by bits 9:7 with a0 and the register named by bits 4:2 with a1.
- R4: A gather whose two operand fields are equal is legal: a0 and a1 both receive that one register's value.
- R5: A scatter whose two operand fields are equal raises `illegal` in its acceptance cycle. It issues no write and does not raise `irq_block`.
- R6: A valid word that does not match either pattern (another opcode, or bits 6:5 equal to 00 or 10) produces no write, no `illegal` and no `irq_block`.
- R7: With DUAL_WRITE=1 both writes are issued in the acceptance cycle, on ports 0 and 1, and `busy` stays low.
- R8: With DUAL_WRITE=0 only port 0 writes. The first destination is written in the acceptance cycle and the second in the next cycle, and `busy` is high in both of these cycles.
- R9: Both source values are taken in the acceptance cycle. If a source register changes after acceptance, the second write still carries the value it had at acceptance.
- R10: `irq_block` is high in every cycle that issues a pair write. While `busy` is high, `instr_valid` is ignored: a second instruction offered then is neither executed nor flagged as illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is offered this cycle |
| instr | input | 16 | Compressed instruction word |
| rd_addr0 | output | 5 | Register file read address, first source |
| rd_addr1 | output | 5 | Register file read address, second source |
| rd_data0 | input | XLEN | Read data for rd_addr0, same cycle |
| rd_data1 | input | XLEN | Read data for rd_addr1, same cycle |
| wr_en0 | output | 1 | Write request, port 0 |
| wr_addr0 | output | 5 | Write address, port 0 |
| wr_data0 | output | XLEN | Write data, port 0 |
| wr_en1 | output | 1 | Write request, port 1 (DUAL_WRITE=1 only) |
| wr_addr1 | output | 5 | Write address, port 1 |
| wr_data1 | output | XLEN | Write data, port 1 |
| illegal | output | 1 | Reserved encoding accepted this cycle |
| irq_block | output | 1 | Interrupts must not be taken this cycle |
| busy | output | 1 | A two-cycle pair is in flight |

## Verification
The checks on the pairing of writes assume that the register file answers a read within the same cycle. They also assume that `instr_valid` is only acted on in cycles where `busy` is low. This makes the ordering rule (a first write without a pending second is always followed by exactly one more) hold by construction of the stimulus, even when the bench keeps `instr_valid` high through the busy window. The random stimulus never delivers a read value later than the cycle it was requested. It offers illegal and foreign words only through `instr`, so they reach the design only through the decode path the assertions observe. Both variants are driven with every operand combination of both instructions, and a bench-side overwrite of a source register between the two cycles exercises R9.

// File: rtl/pairmv_pkg.sv
package pairmv_pkg;

    localparam int PM_AW = 5;

    typedef logic [PM_AW-1:0] pm_xreg_t;

    localparam pm_xreg_t   PM_REG_A0   = 5'd10;
    localparam pm_xreg_t   PM_REG_A1   = 5'd11;
    localparam logic [5:0] PM_HI_MATCH = 6'b101011;
    localparam logic [1:0] PM_LO_MATCH = 2'b10;
    localparam logic [1:0] PM_SEL_GATH = 2'b11;
    localparam logic [1:0] PM_SEL_SCAT = 2'b01;

    typedef enum logic [1:0] {
        PM_OP_NONE   = 2'd0,
        PM_OP_GATHER = 2'd1,
        PM_OP_SCATTER = 2'd2
    } pm_op_e;

    typedef struct packed {
        pm_op_e   op;
        logic     reserved;
        pm_xreg_t src0;
        pm_xreg_t src1;
        pm_xreg_t dst0;
        pm_xreg_t dst1;
    } pm_dec_t;

    // saved index -> architectural register across the split range
    function automatic pm_xreg_t pm_sreg_to_xreg(input logic [2:0] sidx);
        pm_xreg_t base;
        base = (sidx[2:1] == 2'b00) ? 5'd8 : 5'd16;
        return base + {2'b00, sidx};
    endfunction

    // true for every register a pair move is allowed to write
    function automatic logic pm_is_pair_reg(input pm_xreg_t r);
        return (r == 5'd8) || (r == 5'd9) || (r == PM_REG_A0) ||
               (r == PM_REG_A1) || ((r >= 5'd18) && (r <= 5'd23));
    endfunction

endpackage

// File: rtl/pairmv_xmap.sv
module pairmv_xmap
    import pairmv_pkg::*;
(
    input  logic [2:0] sreg_i,
    output pm_xreg_t   xreg_o
);
    assign xreg_o = pm_sreg_to_xreg(sreg_i);
endmodule

// File: rtl/pairmv_decode.sv
module pairmv_decode
    import pairmv_pkg::*;
(
    input  logic [15:0] instr_i,
    output pm_dec_t     dec_o
);
    localparam int N_OPND = 2;

    logic [2:0] sfield [N_OPND];
    pm_xreg_t   xmapped [N_OPND];

    assign sfield[0] = instr_i[9:7];
    assign sfield[1] = instr_i[4:2];

    for (genvar g = 0; g < N_OPND; g++) begin : g_map
        pairmv_xmap u_map (
            .sreg_i (sfield[g]),
            .xreg_o (xmapped[g])
        );
    end

    logic pattern_hit;
    assign pattern_hit = (instr_i[15:10] == PM_HI_MATCH) &&
                         (instr_i[1:0]   == PM_LO_MATCH);

    always_comb begin
        dec_o          = '0;
        dec_o.op       = PM_OP_NONE;
        if (pattern_hit) begin
            unique case (instr_i[6:5])
                PM_SEL_GATH: begin
                    dec_o.op   = PM_OP_GATHER;
                    dec_o.src0 = xmapped[0];
                    dec_o.src1 = xmapped[1];
                    dec_o.dst0 = PM_REG_A0;
                    dec_o.dst1 = PM_REG_A1;
                end
                PM_SEL_SCAT: begin
                    dec_o.op       = PM_OP_SCATTER;
                    dec_o.src0     = PM_REG_A0;
                    dec_o.src1     = PM_REG_A1;
                    dec_o.dst0     = xmapped[0];
                    dec_o.dst1     = xmapped[1];
                    dec_o.reserved = (sfield[0] == sfield[1]);
                end
                default: dec_o.op = PM_OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pairmv_wr_dual.sv
module pairmv_wr_dual
    import pairmv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            go_i,
    input  pm_xreg_t        dst0_i,
    input  pm_xreg_t        dst1_i,
    input  logic [XLEN-1:0] val0_i,
    input  logic [XLEN-1:0] val1_i,
    output logic            wen0_o,
    output pm_xreg_t        waddr0_o,
    output logic [XLEN-1:0] wdata0_o,
    output logic            wen1_o,
    output pm_xreg_t        waddr1_o,
    output logic [XLEN-1:0] wdata1_o,
    output logic            pend_o
);
    // both halves land on the same clock edge
    assign wen0_o   = go_i;
    assign waddr0_o = dst0_i;
    assign wdata0_o = val0_i;
    assign wen1_o   = go_i;
    assign waddr1_o = dst1_i;
    assign wdata1_o = val1_i;
    assign pend_o   = 1'b0;
endmodule

// File: rtl/pairmv_wr_seq.sv
module pairmv_wr_seq
    import pairmv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go_i,
    input  pm_xreg_t        dst0_i,
    input  pm_xreg_t        dst1_i,
    input  logic [XLEN-1:0] val0_i,
    input  logic [XLEN-1:0] val1_i,
    output logic            wen0_o,
    output pm_xreg_t        waddr0_o,
    output logic [XLEN-1:0] wdata0_o,
    output logic            wen1_o,
    output pm_xreg_t        waddr1_o,
    output logic [XLEN-1:0] wdata1_o,
    output logic            pend_o
);
    logic            pend_q;
    pm_xreg_t        addr_q;
    logic [XLEN-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else if (go_i) begin
            pend_q <= 1'b1;
            addr_q <= dst1_i;
            data_q <= val1_i;   // second source frozen at acceptance
        end else begin
            pend_q <= 1'b0;
        end
    end

    assign wen0_o   = go_i | pend_q;
    assign waddr0_o = pend_q ? addr_q : dst0_i;
    assign wdata0_o = pend_q ? data_q : val0_i;
    assign wen1_o   = 1'b0;
    assign waddr1_o = '0;
    assign wdata1_o = '0;
    assign pend_o   = pend_q;
endmodule

// File: rtl/pairmv_seq.sv
module pairmv_seq
    import pairmv_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter bit DUAL_WRITE = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [15:0]     instr,
    output logic [4:0]      rd_addr0,
    output logic [4:0]      rd_addr1,
    input  logic [XLEN-1:0] rd_data0,
    input  logic [XLEN-1:0] rd_data1,
    output logic            wr_en0,
    output logic [4:0]      wr_addr0,
    output logic [XLEN-1:0] wr_data0,
    output logic            wr_en1,
    output logic [4:0]      wr_addr1,
    output logic [XLEN-1:0] wr_data1,
    output logic            illegal,
    output logic            irq_block,
    output logic            busy
);
    pm_dec_t dec;
    logic    accept;
    logic    go;
    logic    second_pend;

    pairmv_decode u_dec (
        .instr_i (instr),
        .dec_o   (dec)
    );

    assign accept   = instr_valid & ~second_pend;
    assign go       = accept & (dec.op != PM_OP_NONE) & ~dec.reserved;
    assign illegal  = accept & dec.reserved;
    assign rd_addr0 = dec.src0;
    assign rd_addr1 = dec.src1;

    if (DUAL_WRITE) begin : g_dual
        pairmv_wr_dual #(.XLEN(XLEN)) u_eng (
            .go_i     (go),
            .dst0_i   (dec.dst0),
            .dst1_i   (dec.dst1),
            .val0_i   (rd_data0),
            .val1_i   (rd_data1),
            .wen0_o   (wr_en0),
            .waddr0_o (wr_addr0),
            .wdata0_o (wr_data0),
            .wen1_o   (wr_en1),
            .waddr1_o (wr_addr1),
            .wdata1_o (wr_data1),
            .pend_o   (second_pend)
        );
    end else begin : g_seq
        pairmv_wr_seq #(.XLEN(XLEN)) u_eng (
            .clk      (clk),
            .rst      (rst),
            .go_i     (go),
            .dst0_i   (dec.dst0),
            .dst1_i   (dec.dst1),
            .val0_i   (rd_data0),
            .val1_i   (rd_data1),
            .wen0_o   (wr_en0),
            .waddr0_o (wr_addr0),
            .wdata0_o (wr_data0),
            .wen1_o   (wr_en1),
            .waddr1_o (wr_addr1),
            .wdata1_o (wr_data1),
            .pend_o   (second_pend)
        );
    end

    assign irq_block = go | second_pend;
    assign busy      = DUAL_WRITE ? 1'b0 : (go | second_pend);
endmodule

// File: rtl/pairmv_chk.sv
module pairmv_chk
    import pairmv_pkg::*;
#(
    parameter bit DUAL_WRITE = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       instr_valid,
    input logic       wr_en0,
    input logic [4:0] wr_addr0,
    input logic       wr_en1,
    input logic [4:0] wr_addr1,
    input logic       illegal,
    input logic       irq_block,
    input logic       busy,
    input logic       second_pend
);
    a_r1_port0_target: assert property (@(posedge clk) disable iff (rst)
        wr_en0 |-> pm_is_pair_reg(wr_addr0));

    a_r1_port1_target: assert property (@(posedge clk) disable iff (rst)
        wr_en1 |-> pm_is_pair_reg(wr_addr1));

    a_r3_distinct_dests: assert property (@(posedge clk) disable iff (rst)
        (wr_en0 && wr_en1) |-> (wr_addr0 != wr_addr1));

    a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!wr_en0 && !wr_en1 && !irq_block));

    a_r6_illegal_needs_valid: assert property (@(posedge clk) disable iff (rst)
        illegal |-> instr_valid);

    a_r7_paired_ports: assert property (@(posedge clk) disable iff (rst)
        (DUAL_WRITE && (wr_en0 || wr_en1)) |-> (wr_en0 && wr_en1 && !busy));

    a_r8_single_port: assert property (@(posedge clk) disable iff (rst)
        (!DUAL_WRITE && busy) |-> !wr_en1);

    a_r8_second_follows: assert property (@(posedge clk) disable iff (rst)
        (!DUAL_WRITE && wr_en0 && !second_pend) |=> (wr_en0 && second_pend && busy));

    a_r10_block_on_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en0 || wr_en1) |-> irq_block);

    a_r10_no_illegal_while_pending: assert property (@(posedge clk) disable iff (rst)
        second_pend |-> !illegal);
endmodule

bind pairmv_seq pairmv_chk #(.DUAL_WRITE(DUAL_WRITE)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .wr_en0      (wr_en0),
    .wr_addr0    (wr_addr0),
    .wr_en1      (wr_en1),
    .wr_addr1    (wr_addr1),
    .illegal     (illegal),
    .irq_block   (irq_block),
    .busy        (busy),
    .second_pend (second_pend)
);

// File: tb/pairmv_seq_tb_top.sv
module pairmv_seq_tb_top;
    localparam int CLK_P = 10;
    localparam int XLEN  = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_P/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // ---------------- dual-port instance ----------------
    logic            va = 1'b0;
    logic [15:0]     ia = '0;
    logic [4:0]      ra0, ra1, wa0, wa1;
    logic [XLEN-1:0] rda0, rda1, wda0, wda1;
    logic            wea0, wea1, illa, blka, busa;
    logic [XLEN-1:0] rf_a  [32];
    logic [XLEN-1:0] exp_a [32];

    pairmv_seq #(.XLEN(XLEN), .DUAL_WRITE(1'b1)) dut_i (
        .clk(clk), .rst(rst), .instr_valid(va), .instr(ia),
        .rd_addr0(ra0), .rd_addr1(ra1), .rd_data0(rda0), .rd_data1(rda1),
        .wr_en0(wea0), .wr_addr0(wa0), .wr_data0(wda0),
        .wr_en1(wea1), .wr_addr1(wa1), .wr_data1(wda1),
        .illegal(illa), .irq_block(blka), .busy(busa)
    );

    // ---------------- single-port instance ----------------
    logic            vb = 1'b0;
    logic [15:0]     ib = '0;
    logic [4:0]      rb0, rb1, wb0, wb1;
    logic [XLEN-1:0] rdb0, rdb1, wdb0, wdb1;
    logic            web0, web1, illb, blkb, busb;
    logic [XLEN-1:0] rf_b  [32];
    logic [XLEN-1:0] exp_b [32];
    logic            pk_en = 1'b0;
    logic [4:0]      pk_addr = '0;
    logic [XLEN-1:0] pk_data = '0;

    pairmv_seq #(.XLEN(XLEN), .DUAL_WRITE(1'b0)) dut_seq_i (
        .clk(clk), .rst(rst), .instr_valid(vb), .instr(ib),
        .rd_addr0(rb0), .rd_addr1(rb1), .rd_data0(rdb0), .rd_data1(rdb1),
        .wr_en0(web0), .wr_addr0(wb0), .wr_data0(wdb0),
        .wr_en1(web1), .wr_addr1(wb1), .wr_data1(wdb1),
        .illegal(illb), .irq_block(blkb), .busy(busb)
    );

    function automatic logic [XLEN-1:0] init_val(input int i);
        return (32'h9E37_79B9 * (i + 1)) ^ (32'h0001_0000 * i);
    endfunction

    function automatic logic [4:0] sx(input logic [2:0] n);
        return (n < 3'd2) ? 5'(int'(n) + 8) : 5'(int'(n) + 16);
    endfunction

    // 0 foreign, 1 gather, 2 scatter, 3 reserved scatter
    function automatic int kind_of(input logic [15:0] w);
        if (w[15:10] != 6'b101011 || w[1:0] != 2'b10) return 0;
        if (w[6:5] == 2'b11) return 1;
        if (w[6:5] == 2'b01) return (w[9:7] == w[4:2]) ? 3 : 2;
        return 0;
    endfunction

    function automatic logic [15:0] enc(input bit gather, input logic [2:0] r1, input logic [2:0] r2);
        return {6'b101011, r1, (gather ? 2'b11 : 2'b01), r2, 2'b10};
    endfunction

    // bench register files with same-cycle reads
    assign rda0 = rf_a[ra0];
    assign rda1 = rf_a[ra1];
    assign rdb0 = rf_b[rb0];
    assign rdb1 = rf_b[rb1];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) begin
                rf_a[i] <= init_val(i);
                rf_b[i] <= init_val(i);
            end
        end else begin
            if (wea0 && wa0 != 5'd0) rf_a[wa0] <= wda0;
            if (wea1 && wa1 != 5'd0) rf_a[wa1] <= wda1;
            if (web0 && wb0 != 5'd0) rf_b[wb0] <= wdb0;
            if (web1 && wb1 != 5'd0) rf_b[wb1] <= wdb1;
            if (pk_en) rf_b[pk_addr] <= pk_data;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    function automatic string tag_of(input int k, input logic [15:0] w);
        case (k)
            1: return (w[9:7] == w[4:2]) ? "R4" : "R2";
            2: return "R3";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    // apply expected effect of a legal op on a model, optional poke afterwards
    task automatic model_op(input bit on_b, input logic [15:0] w,
                            input bit pk, input logic [4:0] pa, input logic [XLEN-1:0] pd);
        int k;
        logic [XLEN-1:0] v1, v2;
        logic [4:0] s1, s2;
        k  = kind_of(w);
        s1 = sx(w[9:7]);
        s2 = sx(w[4:2]);
        if (k == 1) begin
            v1 = on_b ? exp_b[s1] : exp_a[s1];
            v2 = on_b ? exp_b[s2] : exp_a[s2];
            if (on_b) begin
                if (pk) exp_b[pa] = pd;
                exp_b[10] = v1; exp_b[11] = v2;
            end else begin
                exp_a[10] = v1; exp_a[11] = v2;
            end
        end else if (k == 2) begin
            v1 = on_b ? exp_b[10] : exp_a[10];
            v2 = on_b ? exp_b[11] : exp_a[11];
            if (on_b) begin
                if (pk) exp_b[pa] = pd;
                exp_b[s1] = v1; exp_b[s2] = v2;
            end else begin
                exp_a[s1] = v1; exp_a[s2] = v2;
            end
        end
    endtask

    task automatic cmp_regs(input bit on_b, input logic [15:0] w, input string tag);
        logic [4:0] lst [4];
        lst[0] = 5'd10; lst[1] = 5'd11; lst[2] = sx(w[9:7]); lst[3] = sx(w[4:2]);
        for (int j = 0; j < 4; j++) begin
            if (on_b) chk(rf_b[lst[j]] === exp_b[lst[j]], tag, $sformatf("seq x%0d", lst[j]), rf_b[lst[j]], exp_b[lst[j]]);
            else      chk(rf_a[lst[j]] === exp_a[lst[j]], tag, $sformatf("dual x%0d", lst[j]), rf_a[lst[j]], exp_a[lst[j]]);
        end
    endtask

    task automatic run_a(input logic [15:0] w);
        int k;
        string t;
        bit lg;
        k  = kind_of(w);
        t  = tag_of(k, w);
        lg = (k == 1 || k == 2);
        @(negedge clk);
        va = 1'b1; ia = w;
        #(CLK_P/4);
        chk(illa == (k == 3), t, "dual illegal", 32'(illa), 32'(k == 3));
        chk(wea0 == lg && wea1 == lg, (k == 1 || k == 2) ? "R7" : t, "dual write enables",
            {30'd0, wea1, wea0}, {30'd0, lg, lg});
        chk(blka == lg, "R10", "dual irq_block", 32'(blka), 32'(lg));
        chk(busa == 1'b0, "R7", "dual busy", 32'(busa), 32'd0);
        if (lg) begin
            chk(wa0 == (k == 1 ? 5'd10 : sx(w[9:7])), "R1", "dual wr_addr0", 32'(wa0),
                32'(k == 1 ? 5'd10 : sx(w[9:7])));
            chk(wa1 == (k == 1 ? 5'd11 : sx(w[4:2])), "R1", "dual wr_addr1", 32'(wa1),
                32'(k == 1 ? 5'd11 : sx(w[4:2])));
        end
        model_op(1'b0, w, 1'b0, 5'd0, '0);
        @(negedge clk);
        va = 1'b0;
        cmp_regs(1'b0, w, t);
    endtask

    // two-cycle variant; w2 is offered while busy and must be ignored
    task automatic run_b(input logic [15:0] w, input logic [15:0] w2, input bit pk,
                         input logic [XLEN-1:0] pd);
        int k;
        string t;
        logic [4:0] d0, d1, pa;
        k  = kind_of(w);
        t  = tag_of(k, w);
        d0 = (k == 1) ? 5'd10 : sx(w[9:7]);
        d1 = (k == 1) ? 5'd11 : sx(w[4:2]);
        pa = sx(w[4:2]);
        @(negedge clk);
        vb = 1'b1; ib = w;
        pk_en = pk && (k == 1); pk_addr = pa; pk_data = pd;
        #(CLK_P/4);
        if (k == 1 || k == 2) begin
            chk(web0 && wb0 == d0, "R8", "seq first write addr", {26'd0, web0, wb0}, {26'd0, 1'b1, d0});
            chk(busb && blkb && !web1, "R8", "seq busy/block cycle0", {29'd0, busb, blkb, web1}, 32'b110);
            model_op(1'b1, w, pk && (k == 1), pa, pd);
            @(negedge clk);
            pk_en = 1'b0;
            ib = w2;                       // offered while busy
            #(CLK_P/4);
            chk(web0 && wb0 == d1, "R8", "seq second write addr", {26'd0, web0, wb0}, {26'd0, 1'b1, d1});
            chk(busb && blkb, "R10", "seq busy/block cycle1", {30'd0, busb, blkb}, 32'b11);
            chk(!illb, "R10", "seq illegal while busy", 32'(illb), 32'd0);
            @(negedge clk);
            vb = 1'b0;
            #(CLK_P/4);
            chk(!busb && !web0, "R8", "seq idle after pair", {30'd0, busb, web0}, 32'd0);
            cmp_regs(1'b1, w, pk && (k == 1) ? "R9" : t);
        end else begin
            chk(illb == (k == 3), t, "seq illegal", 32'(illb), 32'(k == 3));
            chk(!web0 && !web1 && !busb && !blkb, t, "seq quiet", {28'd0, web0, web1, busb, blkb}, 32'd0);
            @(negedge clk);
            vb = 1'b0; pk_en = 1'b0;
            cmp_regs(1'b1, w, t);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] w;
        void'($urandom(32'd2718));
        for (int i = 0; i < 32; i++) begin
            exp_a[i] = init_val(i);
            exp_b[i] = init_val(i);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #(CLK_P/4);
        chk(!wea0 && !wea1 && !illa && !blka && !busa, "R7", "dual reset quiet",
            {27'd0, wea0, wea1, illa, blka, busa}, 32'd0);
        chk(!web0 && !web1 && !illb && !blkb && !busb, "R8", "seq reset quiet",
            {27'd0, web0, web1, illb, blkb, busb}, 32'd0);

        // exhaustive operand sweep, both forms, both variants
        for (int g = 0; g < 2; g++)
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++) begin
                    run_a(enc(g == 1, 3'(a), 3'(b)));
                    run_b(enc(g == 1, 3'(a), 3'(b)), enc(1'b0, 3'(b), 3'(b)), 1'b0, '0);
                end

        // directed: foreign selector values and a foreign opcode
        run_a({6'b101011, 3'd2, 2'b00, 3'd5, 2'b10});
        run_a({6'b101011, 3'd2, 2'b10, 3'd5, 2'b10});
        run_a({6'b100011, 3'd2, 2'b11, 3'd5, 2'b10});
        run_b({6'b101011, 3'd7, 2'b10, 3'd1, 2'b10}, 16'h0, 1'b0, '0);

        // source overwritten after acceptance (R9)
        run_b(enc(1'b1, 3'd3, 3'd4), 16'h0, 1'b1, 32'hDEAD_BEEF);
        run_b(enc(1'b1, 3'd0, 3'd7), enc(1'b1, 3'd1, 3'd1), 1'b1, 32'h1234_5678);

        // constrained random mix
        for (int n = 0; n < 300; n++) begin
            w = 16'($urandom);
            if ($urandom % 4 != 0) begin
                w[15:10] = 6'b101011;
                w[1:0]   = 2'b10;
            end
            run_a(w);
            run_b(w, 16'($urandom), ($urandom % 5) == 0, $urandom);
        end

        // final full comparison of both register files
        for (int i = 0; i < 32; i++) begin
            chk(rf_a[i] === exp_a[i], "R2", $sformatf("final dual x%0d", i), rf_a[i], exp_a[i]);
            chk(rf_b[i] === exp_b[i], "R3", $sformatf("final seq x%0d", i), rf_b[i], exp_b[i]);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule